// File: doc/BRIEF.md
# Capture/Compare Timer Status Flags

This block is one channel of a general-purpose timer. A 16-bit up-counter advances by one on each enable pulse. Four general registers sit beside it. Each one works either as a capture register, which grabs the counter value when its strobe fires, or as a compare register, which signals when the counter reaches the value it holds. A five-bit status register records these events: one flag for counter wrap and one flag per general register. Each flag can raise its own interrupt request.

Software clears a flag with a two-step handshake. It first reads the status register and sees the flag at 1. It then writes 0 to that bit. A write without that earlier read leaves the flag alone, so an event that arrives between the read and the write is never lost. The counter, the general registers and the interrupt-enable register are all reached through the same simple register bus.

Top module: `tmrcc_capcmp`

## Requirements
- R1: The status register is at address 0. Bit 4 is the wrap flag. Bits 3, 2, 1 and 0 are the flags of general registers 3, 2, 1 and 0 in that order. Bits 15 to 5 always read 0 and ignore writes.
- R2: After reset, every flag and every interrupt enable is 0, the counter is 0x0000, and every general register is 0xFFFF.
- R3: The wrap flag sets when an enable pulse moves the counter from 0xFFFF to 0x0000. A bus write to the counter never sets it.
- R4: When a register is in capture mode (its cap_mode_i bit is 1), its strobe copies the counter value of that cycle into the register and sets its flag. In that cycle the capture takes priority over a bus write to the same register. In compare mode the strobe has no effect.
- R5: When a register is in compare mode, its flag sets once, on the cycle the counter first equals the register. If the equality simply persists, the flag does not set again after it has been cleared.
- R6: A bus read of the status register arms every flag it returns as 1. A later write of 0 to a bit clears that flag only if the flag is armed. A write of 0 to a flag that is not armed leaves it set.
- R7: Writing 1 to a flag has no effect. Any write to the status register disarms all flags, so a second 0-write after that write does not clear anything.
- R8: If a set event and a qualifying clear write fall in the same cycle, the flag stays 1.
- R9: Interrupt-request bit i is 1 exactly when flag i is 1 and enable bit i is 1. The enable register is at address 1, in bits 4 to 0.
- R10: The counter, at address 2, rises by one on each cycle that cnt_inc_i is high. A bus write to the counter loads the written value and takes priority over an increment in the same cycle.
- R11: General registers 0 to 3 are at addresses 4 to 7. They, the counter and the enable register read back the values written to them. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| cnt_inc_i | input | 1 | Counter enable pulse |
| cap_strobe_i | input | 4 | Capture strobe, one per general register |
| cap_mode_i | input | 4 | Per register: 1 = capture, 0 = compare |
| irq_o | output | 5 | Interrupt request per flag, same bit order as status |

## Verification
The bench targets the clear handshake. It writes 0 before any read, writes 1 after a read, and issues a second 0-write after the arming has been used up. A design that clears without the arming read, or that keeps the arming across writes, leaves a flag in the wrong state. The bench also makes a set event and a clear write land in the same cycle, and a capture collide with a bus write. Here, losing the set event, or letting the bus write win, shows up as a wrong flag or a wrong register value.

For compare mode, the bench holds the counter at a matching value after the flag is cleared. A level-sensitive match would set the flag again. For the wrap flag, the bench writes 0xFFFF and then 0x0000 into the counter by software, which must leave the flag clear. It then counts through the wrap, which must set the flag.

// File: rtl/tmrcc_pkg.sv
// Shared sizes and register addresses for the capture/compare timer channel.
package tmrcc_pkg;
    localparam int unsigned CNT_W    = 16;
    localparam int unsigned NUM_GR   = 4;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned NUM_FLAG = NUM_GR + 1;
    localparam int unsigned OVF_BIT  = NUM_GR;

    localparam logic [ADDR_W-1:0] ADR_STATUS  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_IEN     = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_COUNT   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_GR_BASE = 3'd4;
endpackage

// File: rtl/tmrcc_counter.sv
// Free-running up-counter with a software load port.
// It assumes that a load and an increment in the same cycle resolve to the load.
// wrap_o pulses in the cycle whose increment takes the counter from all-ones to zero.
module tmrcc_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    // Load takes priority over increment; reset clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (ld_i)   cnt_q <= ld_val_i;
        else if (inc_i)  cnt_q <= cnt_q + 1'b1;
    end

    // Wrap event: only a real increment from all-ones counts, never a load.
    always_comb wrap_o = inc_i & ~ld_i & (&cnt_q);

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tmrcc_gr.sv
// One general register, acting as a capture or a compare register.
// Capture mode: the strobe copies the counter and raises hit_o; it takes priority over a bus write.
// Compare mode: hit_o pulses on the first cycle in which the counter equals the register.
// It assumes cap_mode_i is a quasi-static configuration input.
module tmrcc_gr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_mode_i,
    input  logic         cap_i,
    input  logic [W-1:0] cnt_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] gr_o,
    output logic         hit_o
);
    logic [W-1:0] gr_q;
    logic         cap_ev;
    logic         eq_now;
    logic         eq_q;

    // Event qualification for both modes.
    always_comb begin
        cap_ev = cap_mode_i & cap_i;
        eq_now = ~cap_mode_i & (cnt_i == gr_q);
        hit_o  = cap_ev | (eq_now & ~eq_q);
    end

    // Register contents: a capture beats a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)      gr_q <= '1;
        else if (cap_ev) gr_q <= cnt_i;
        else if (wr_i)   gr_q <= wdata_i;
    end

    // Remembers the previous equality so that a match is reported only on its first cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq_now;
    end

    assign gr_o = gr_q;
endmodule

// File: rtl/tmrcc_flags.sv
// Status flags with read-then-write-zero clearing and gated interrupt requests.
// A status read arms each flag it returns as 1. A status write clears the armed flags
// whose data bit is 0, then disarms every flag. A set event always beats a clear.
module tmrcc_flags #(
    parameter int unsigned NF = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [NF-1:0] wdata_i,
    input  logic [NF-1:0] ien_i,
    output logic [NF-1:0] flags_o,
    output logic [NF-1:0] armed_o,
    output logic [NF-1:0] irq_o
);
    logic [NF-1:0] flags_q, armed_q;
    logic [NF-1:0] clr, flags_nxt, armed_nxt;

    // Next-state logic for the flags and for their arming bits.
    always_comb begin
        clr       = {NF{wr_i}} & ~wdata_i & armed_q;
        flags_nxt = set_i | (flags_q & ~clr);
        if (wr_i)      armed_nxt = '0;
        else if (rd_i) armed_nxt = armed_q | flags_q;
        else           armed_nxt = armed_q;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            armed_q <= '0;
        end else begin
            flags_q <= flags_nxt;
            armed_q <= armed_nxt;
        end
    end

    assign flags_o = flags_q;
    assign armed_o = armed_q;
    assign irq_o   = flags_q & ien_i;
endmodule

// File: rtl/tmrcc_capcmp.sv
// Top of the capture/compare timer channel: bus decode, interrupt enables and read mux.
// It assumes a single-cycle bus: one access per cycle, with read data valid combinationally.
module tmrcc_capcmp
    import tmrcc_pkg::*;
#(
    parameter int unsigned CW = CNT_W,
    parameter int unsigned NG = NUM_GR,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel_i,
    input  logic          bus_wr_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [CW-1:0] bus_wdata_i,
    output logic [CW-1:0] bus_rdata_o,
    input  logic          cnt_inc_i,
    input  logic [NG-1:0] cap_strobe_i,
    input  logic [NG-1:0] cap_mode_i,
    output logic [NG:0]   irq_o
);
    localparam int unsigned NF = NG + 1;

    logic                   wr_stb, rd_stb;
    logic                   st_wr, st_rd, ien_wr, cnt_wr;
    logic [NG-1:0]          gr_wr;
    logic [NF-1:0]          ien_q;
    logic [CW-1:0]          cnt_q;
    logic                   wrap;
    logic [NG-1:0][CW-1:0]  gr_q;
    logic [NG-1:0]          hit;
    logic [NF-1:0]          set_ev;
    logic [NF-1:0]          flags_q, armed_q;

    // Address decode for every register.
    always_comb begin
        wr_stb = bus_sel_i & bus_wr_i;
        rd_stb = bus_sel_i & ~bus_wr_i;
        st_wr  = wr_stb & (bus_addr_i == ADR_STATUS);
        st_rd  = rd_stb & (bus_addr_i == ADR_STATUS);
        ien_wr = wr_stb & (bus_addr_i == ADR_IEN);
        cnt_wr = wr_stb & (bus_addr_i == ADR_COUNT);
    end

    // Interrupt-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= bus_wdata_i[NF-1:0];
    end

    tmrcc_counter #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (cnt_inc_i),
        .ld_i     (cnt_wr),
        .ld_val_i (bus_wdata_i),
        .cnt_o    (cnt_q),
        .wrap_o   (wrap)
    );

    for (genvar g = 0; g < NG; g++) begin : g_gr
        assign gr_wr[g] = wr_stb & (bus_addr_i == ADR_GR_BASE + AW'(g));
        tmrcc_gr #(.W(CW)) u_gr (
            .clk        (clk),
            .rst_n      (rst_n),
            .cap_mode_i (cap_mode_i[g]),
            .cap_i      (cap_strobe_i[g]),
            .cnt_i      (cnt_q),
            .wr_i       (gr_wr[g]),
            .wdata_i    (bus_wdata_i),
            .gr_o       (gr_q[g]),
            .hit_o      (hit[g])
        );
    end

    assign set_ev = {wrap, hit};

    tmrcc_flags #(.NF(NF)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_ev),
        .rd_i    (st_rd),
        .wr_i    (st_wr),
        .wdata_i (bus_wdata_i[NF-1:0]),
        .ien_i   (ien_q),
        .flags_o (flags_q),
        .armed_o (armed_q),
        .irq_o   (irq_o)
    );

    // Read mux; reserved bits and unused addresses return zero.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADR_STATUS)     bus_rdata_o[NF-1:0] = flags_q;
        else if (bus_addr_i == ADR_IEN)   bus_rdata_o[NF-1:0] = ien_q;
        else if (bus_addr_i == ADR_COUNT) bus_rdata_o = cnt_q;
        for (int g = 0; g < NG; g++) begin
            if (bus_addr_i == ADR_GR_BASE + AW'(g)) bus_rdata_o = gr_q[g];
        end
    end
endmodule

// File: rtl/tmrcc_capcmp_chk.sv
// Property checker for tmrcc_capcmp, attached with bind below.
module tmrcc_capcmp_chk #(
    parameter int unsigned W  = 16,
    parameter int unsigned NG = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel_i,
    input logic                 bus_wr_i,
    input logic [2:0]           bus_addr_i,
    input logic [W-1:0]         bus_rdata_o,
    input logic                 cnt_inc_i,
    input logic                 cnt_wr,
    input logic [NG-1:0]        cap_strobe_i,
    input logic [NG-1:0]        cap_mode_i,
    input logic [W-1:0]         cnt_q,
    input logic [NG-1:0][W-1:0] gr_q,
    input logic [NG:0]          set_ev,
    input logic [NG:0]          flags_q,
    input logic [NG:0]          armed_q,
    input logic [NG:0]          irq_o
);
    // R1: reserved status bits read as zero.
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_wr_i && bus_addr_i == 3'd0) |-> (bus_rdata_o[W-1:NG+1] == '0));

    // R3: the wrap flag rises only after an increment from all-ones.
    p_ovf_from_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[NG]) |-> ($past(cnt_q) == {W{1'b1}} && $past(cnt_inc_i) && !$past(cnt_wr)));

    // R10: an increment without a load advances the counter by one.
    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc_i && !cnt_wr) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

    // R9: no request without its flag.
    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~flags_q) == '0));

    for (genvar i = 0; i <= NG; i++) begin : g_flag
        // R6: a flag only falls if it was armed by a read.
        p_clear_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags_q[i]) |-> $past(armed_q[i]));
        // R8: a set event always leaves the flag at 1.
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> flags_q[i]);
    end

    for (genvar g = 0; g < NG; g++) begin : g_cap
        // R4: a capture stores the counter value of its cycle.
        p_capture_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_mode_i[g] && cap_strobe_i[g]) |=> (gr_q[g] == $past(cnt_q)));
    end
endmodule

bind tmrcc_capcmp tmrcc_capcmp_chk #(.W(CW), .NG(NG)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel_i    (bus_sel_i),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .bus_rdata_o  (bus_rdata_o),
    .cnt_inc_i    (cnt_inc_i),
    .cnt_wr       (cnt_wr),
    .cap_strobe_i (cap_strobe_i),
    .cap_mode_i   (cap_mode_i),
    .cnt_q        (cnt_q),
    .gr_q         (gr_q),
    .set_ev       (set_ev),
    .flags_q      (flags_q),
    .armed_q      (armed_q),
    .irq_o        (irq_o)
);

// File: tb/tmrcc_capcmp_tb_top.sv
// Bench: a behavioural reference model is compared on every clock, plus directed checks.
module tmrcc_capcmp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, inc = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [3:0]  cap = 4'h0, mode = 4'h0;
    logic [15:0] rdata;
    logic [4:0]  irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tmrcc_capcmp dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cnt_inc_i(inc),
        .cap_strobe_i(cap), .cap_mode_i(mode), .irq_o(irq)
    );

    // Reference model state.
    int m_cnt, m_ien, m_flags, m_armed;
    int m_gr[4];
    bit m_eqp[4];
    int n_cnt, n_ien, n_flags, n_armed;
    int n_gr[4];
    bit n_eqp[4];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_read(input int a);
        if (a == 0) return m_flags;
        if (a == 1) return m_ien;
        if (a == 2) return m_cnt;
        if (a >= 4) return m_gr[a-4];
        return 0;
    endfunction

    task automatic m_reset();
        m_cnt = 0; m_ien = 0; m_flags = 0; m_armed = 0;
        foreach (m_gr[g]) begin m_gr[g] = 'hFFFF; m_eqp[g] = 0; end
    endtask

    initial m_reset();

    // Per-clock comparison and model update.
    always begin
        @(negedge clk);
        #3;
        if (rst_n) begin
            chk("R11 read data", int'(rdata), m_read(int'(addr)));
            chk("R9 irq", int'(irq), m_flags & m_ien);
        end
        begin
            bit st_wr, st_rd, cnt_wr;
            int set;
            st_wr  = sel && wr && addr == 0;
            st_rd  = sel && !wr && addr == 0;
            cnt_wr = sel && wr && addr == 2;
            set = (inc && !cnt_wr && m_cnt == 'hFFFF) ? 'h10 : 0;
            n_cnt = cnt_wr ? int'(wdata) : (inc ? ((m_cnt + 1) & 'hFFFF) : m_cnt);
            for (int g = 0; g < 4; g++) begin
                bit capev, eq;
                capev = mode[g] && cap[g];
                eq = !mode[g] && (m_cnt == m_gr[g]);
                if (capev || (eq && !m_eqp[g])) set |= (1 << g);
                n_eqp[g] = eq;
                if (capev) n_gr[g] = m_cnt;
                else if (sel && wr && addr == 3'(4 + g)) n_gr[g] = int'(wdata);
                else n_gr[g] = m_gr[g];
            end
            n_ien = (sel && wr && addr == 1) ? int'(wdata[4:0]) : m_ien;
            n_flags = m_flags;
            for (int i = 0; i < 5; i++) begin
                if (set & (1 << i)) n_flags |= (1 << i);
                else if (st_wr && !wdata[i] && (m_armed & (1 << i))) n_flags &= ~(1 << i);
            end
            n_armed = st_wr ? 0 : (st_rd ? (m_armed | m_flags) : m_armed);
        end
        @(posedge clk);
        if (!rst_n) m_reset();
        else begin
            m_cnt = n_cnt; m_ien = n_ien; m_flags = n_flags; m_armed = n_armed;
            foreach (m_gr[g]) begin m_gr[g] = n_gr[g]; m_eqp[g] = n_eqp[g]; end
        end
    end

    task automatic cyc(input bit s, input bit w, input logic [2:0] a, input logic [15:0] d,
                       input bit i, input logic [3:0] c);
        @(negedge clk);
        sel = s; wr = w; addr = a; wdata = d; inc = i; cap = c;
    endtask

    task automatic idle(); cyc(0, 0, 3'd0, 16'h0, 0, 4'h0); endtask
    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d); cyc(1, 1, a, d, 0, 4'h0); endtask

    task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
        cyc(1, 0, a, 16'h0, 0, 4'h0);
        #2 chk(tag, int'(rdata), exp);
    endtask

    task automatic irq_chk(input int exp, input string tag);
        idle();
        #2 chk(tag, int'(irq), exp);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(); idle();
        // R2: reset values.
        rd_chk(3'd0, 0, "R2 status");
        rd_chk(3'd2, 0, "R2 counter");
        for (int g = 0; g < 4; g++) rd_chk(3'(4 + g), 'hFFFF, "R2 general reg");
        rd_chk(3'd1, 0, "R2 enables");
        // R11: read back of written registers.
        wr_reg(3'd4, 16'h1234); rd_chk(3'd4, 'h1234, "R11 gr0");
        wr_reg(3'd1, 16'hFFFF); rd_chk(3'd1, 'h1F, "R11 enable");
        rd_chk(3'd3, 0, "R11 unused");
        // R1/R7: writing ones and reserved bits changes nothing.
        wr_reg(3'd0, 16'hFFFF); rd_chk(3'd0, 0, "R1 reserved");
        // R10: counting and load priority.
        mode = 4'b0001;
        wr_reg(3'd2, 16'h0100);
        repeat (3) cyc(0, 0, 3'd0, 16'h0, 1, 4'h0);
        rd_chk(3'd2, 'h0103, "R10 increments");
        cyc(1, 1, 3'd2, 16'h0200, 1, 4'h0);
        rd_chk(3'd2, 'h0200, "R10 load wins");
        wr_reg(3'd2, 16'h0103);
        // R4: capture.
        cyc(0, 0, 3'd0, 16'h0, 0, 4'b0001);
        irq_chk('h01, "R9 irq from capture");
        wr_reg(3'd0, 16'h0000);               // not armed
        rd_chk(3'd4, 'h0103, "R4 captured value");
        rd_chk(3'd0, 'h01, "R6 zero-write without read");
        wr_reg(3'd0, 16'h001F);               // ones, consumes arming
        wr_reg(3'd0, 16'h0000);
        rd_chk(3'd0, 'h01, "R7 arming consumed");
        wr_reg(3'd0, 16'h0000);
        rd_chk(3'd0, 0, "R6 read then zero clears");
        // R8: set and clear in the same cycle.
        cyc(0, 0, 3'd0, 16'h0, 0, 4'b0001);
        rd_chk(3'd0, 'h01, "R8 flag set");
        cyc(1, 1, 3'd0, 16'h0000, 0, 4'b0001);
        rd_chk(3'd0, 'h01, "R8 set wins");
        wr_reg(3'd0, 16'h0000);
        // R4: capture beats a bus write.
        cyc(1, 1, 3'd4, 16'hAAAA, 0, 4'b0001);
        rd_chk(3'd4, 'h0103, "R4 capture beats write");
        rd_chk(3'd0, 'h01, "R4 capture flag");
        wr_reg(3'd0, 16'h0000);
        // R5: compare match on register 1.
        wr_reg(3'd5, 16'h0105);
        cyc(0, 0, 3'd0, 16'h0, 1, 4'h0);
        cyc(0, 0, 3'd0, 16'h0, 1, 4'h0);
        idle();
        rd_chk(3'd0, 'h02, "R5 compare sets");
        wr_reg(3'd0, 16'h0000);
        idle(); idle();
        rd_chk(3'd0, 0, "R5 persisting match does not reset");
        cyc(0, 0, 3'd0, 16'h0, 0, 4'b0010);
        rd_chk(3'd5, 'h0105, "R4 strobe ignored in compare");
        rd_chk(3'd0, 0, "R4 no flag in compare");
        // R3: software writes do not set wrap; counting through does.
        wr_reg(3'd2, 16'hFFFF);
        wr_reg(3'd2, 16'h0000);
        idle();
        rd_chk(3'd0, 'h0C, "R3 no wrap on load");
        wr_reg(3'd0, 16'h0000);
        wr_reg(3'd2, 16'hFFFE);
        cyc(0, 0, 3'd0, 16'h0, 1, 4'h0);
        cyc(0, 0, 3'd0, 16'h0, 1, 4'h0);
        idle();
        rd_chk(3'd0, 'h1C, "R3 wrap sets");
        rd_chk(3'd2, 0, "R3 counter wrapped");
        irq_chk('h1C, "R9 all enabled");
        wr_reg(3'd1, 16'h0010);
        irq_chk('h10, "R9 gated by enable");
        idle();
        summary();
    end
endmodule